// File: doc/BRIEF.md
# Asymmetric-Width Byte Buffer

This block is a circular byte store whose write port is wider than its read port. It is the storage core of a FIFO that changes data width. A write puts a whole input word into consecutive byte locations in one clock. A read takes a narrower word from consecutive byte locations in one clock. Each side keeps its own pointer, and that pointer moves forward by the number of bytes the side moves per access.

A byte occupancy count drives two flags. `full` means a further write would not fit. `empty` means too few bytes are stored for a read. A write request while `full` is dropped, and so is a read request while `empty`. The pointers and the stored data then stay as they were. A read and a write may be accepted in the same clock. The read then returns the data that was stored before that edge.

The port widths, the byte size and the address width are parameters. A configuration is rejected at elaboration unless it meets all of these conditions: both port widths are whole multiples of the byte size, the write port is at least as wide as the read port, and the array size is a multiple of both byte counts.

Top module: `asym_byte_buffer`

## Requirements
- R1: While `rst_n` is low at a rising edge, both pointers and the occupancy count return to zero and `rd_data` clears to 0. After that edge `empty` is 1 and `full` is 0.
- R2: The bytes of a write are placed in order of significance. Input byte lane k, bits BYTE_W*k to BYTE_W*k+BYTE_W-1, goes to address wr_ptr+k. Output byte lane k is taken from address rd_ptr+k. A 32-bit write of 0x44332211 with 8-bit bytes therefore reads back as 0x2211 and then 0x4433.
- R3: An accepted write adds WR_W/BYTE_W bytes. `full` is 1 exactly when fewer than WR_W/BYTE_W byte locations are free. A write requested while `full` stores nothing and does not move the write pointer.
- R4: An accepted read removes RD_W/BYTE_W bytes. `empty` is 1 exactly when fewer than RD_W/BYTE_W bytes are held. A read requested while `empty` leaves `rd_data`, the read pointer and the count unchanged.
- R5: Pointers and lane addresses wrap modulo 2^ADDR_W. Data keeps its byte order across any number of passes through the array.
- R6: A read and a write accepted in the same clock both take effect. The count changes by the write byte count minus the read byte count. The read returns the bytes that were stored before that edge.
- R7: `rd_data` is registered. It changes only at a rising edge at which a read is accepted, and it holds its value in every other cycle.
- R8: With the default sizes (16 bytes, write 4, read 2), four writes from empty raise `full`, and eight reads from full raise `empty`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | WR_W | Write word, lowest byte lane at the lowest address |
| full | output | 1 | Not enough free space for one write |
| rd_en | input | 1 | Read request |
| rd_data | output | RD_W | Registered read word |
| empty | output | 1 | Not enough stored bytes for one read |

## Verification
The byte ordering is first tested with a directed word whose lanes all hold different values, so any swapped or shifted lane shows up in the read halves. Further directed runs fill the buffer to `full` and drain it to `empty`, with an extra request made at each limit. These runs separate a dropped request from one that was accepted by mistake, both in the drained data and in `rd_data`. A round-robin pass longer than the array and a seeded random mix of reads, writes and simultaneous accesses check wrap-around and same-cycle ordering against a byte-queue model. Together they show whether a fault lies in the pointer arithmetic or in the occupancy bookkeeping.

// File: rtl/abuf_pkg.sv
// Package: shared configuration check for the asymmetric byte buffer.
// Assumes nothing; pure functions only.
package abuf_pkg;

    // Returns 1 when a width/depth combination is legal for the buffer.
    function automatic bit cfg_ok(int wr_w, int rd_w, int byte_w, int addr_w);
        int depth;
        if (byte_w <= 0 || wr_w <= 0 || rd_w <= 0 || addr_w <= 0) return 1'b0;
        if ((wr_w % byte_w) != 0 || (rd_w % byte_w) != 0) return 1'b0;
        if (wr_w < rd_w) return 1'b0;
        depth = 1 << addr_w;
        if ((depth % (wr_w / byte_w)) != 0) return 1'b0;
        if ((depth % (rd_w / byte_w)) != 0) return 1'b0;
        return 1'b1;
    endfunction

endpackage

// File: rtl/abuf_ptr.sv
// Module: abuf_ptr
// Circular byte pointer that moves by a fixed STEP on each accepted access.
// Assumes STEP divides 2**ADDR_W, so the pointer wraps naturally.
module abuf_ptr #(
    parameter int ADDR_W = 4,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    // Move the pointer forward by STEP bytes, modulo the array size.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= '0;
        else if (adv) ptr <= ptr + STEP_V;
    end

    // R5: an accepted access moves the pointer by exactly STEP, with wrap.
    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> ptr == $past(ptr) + STEP_V);
    // R3/R4: without an accepted access the pointer holds.
    assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr));
endmodule

// File: rtl/abuf_occupancy.sv
// Module: abuf_occupancy
// Byte occupancy counter. Gates the requests into accepted accesses and
// derives full and empty from the registered count.
// Assumes WR_B and RD_B are no larger than 2**ADDR_W.
module abuf_occupancy #(
    parameter int ADDR_W = 4,
    parameter int WR_B   = 4,
    parameter int RD_B   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_req,
    input  logic rd_req,
    output logic wr_fire,
    output logic rd_fire,
    output logic full,
    output logic empty
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CW    = ADDR_W + 1;
    localparam logic [CW-1:0] WR_STEP   = CW'(WR_B);
    localparam logic [CW-1:0] RD_STEP   = CW'(RD_B);
    localparam logic [CW-1:0] FULL_THR  = CW'(DEPTH - WR_B);
    localparam logic [CW-1:0] EMPTY_THR = CW'(RD_B);

    logic [CW-1:0] count;

    // Flags from the registered count.
    always_comb begin
        full    = count > FULL_THR;
        empty   = count < EMPTY_THR;
        wr_fire = wr_req && !full;
        rd_fire = rd_req && !empty;
    end

    // Add the written bytes and subtract the read bytes each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else count <= count + (wr_fire ? WR_STEP : '0) - (rd_fire ? RD_STEP : '0);
    end

    // R3: the count never exceeds the array size.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R3: a write alone while full leaves the count unchanged.
    assert_full_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_req && !rd_req) |=> count == $past(count));
    // R4: a read alone while empty leaves the count unchanged.
    assert_empty_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_req && !wr_req) |=> count == $past(count));
    // R6: simultaneous accepted accesses change the count by the difference.
    assert_both_delta_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && rd_fire) |=> count == $past(count) + WR_STEP - RD_STEP);
endmodule

// File: rtl/abuf_store.sv
// Module: abuf_store
// Byte array with a multi-lane write port and a registered multi-lane
// read port. Lane k uses address pointer+k, modulo the array size.
// Assumes the callers only assert the fire inputs for legal accesses.
module abuf_store #(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 4,
    parameter int WR_B   = 4,
    parameter int RD_B   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_fire,
    input  logic [ADDR_W-1:0]        wr_ptr,
    input  logic [WR_B*BYTE_W-1:0]   wr_data,
    input  logic                     rd_fire,
    input  logic [ADDR_W-1:0]        rd_ptr,
    output logic [RD_B*BYTE_W-1:0]   rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem [DEPTH];

    // Store every input byte lane at consecutive addresses.
    always_ff @(posedge clk) begin
        if (wr_fire) begin
            for (int k = 0; k < WR_B; k++) begin
                mem[wr_ptr + ADDR_W'(k)] <= wr_data[BYTE_W*k +: BYTE_W];
            end
        end
    end

    // Capture consecutive bytes into the output register on an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else if (rd_fire) begin
            for (int k = 0; k < RD_B; k++) begin
                rd_data[BYTE_W*k +: BYTE_W] <= mem[rd_ptr + ADDR_W'(k)];
            end
        end
    end

    // R7: the output register holds in every cycle without an accepted read.
    assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fire |=> $stable(rd_data));
endmodule

// File: rtl/asym_byte_buffer.sv
// Module: asym_byte_buffer (top)
// Circular byte buffer with a wide write port and a narrow read port,
// occupancy flags and protection against overflow and underflow.
// Assumes a single clock. The configuration is checked at elaboration.
module asym_byte_buffer #(
    parameter int WR_W   = 32,
    parameter int RD_W   = 16,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [WR_W-1:0] wr_data,
    output logic            full,
    input  logic            rd_en,
    output logic [RD_W-1:0] rd_data,
    output logic            empty
);
    import abuf_pkg::*;

    localparam int WR_B = WR_W / BYTE_W;
    localparam int RD_B = RD_W / BYTE_W;

    generate
        if (!cfg_ok(WR_W, RD_W, BYTE_W, ADDR_W)) begin : g_bad_cfg
            initial $fatal(1, "asym_byte_buffer: illegal width/depth configuration");
        end
    endgenerate

    logic              wr_fire, rd_fire;
    logic [ADDR_W-1:0] wr_ptr, rd_ptr;

    abuf_occupancy #(.ADDR_W(ADDR_W), .WR_B(WR_B), .RD_B(RD_B)) u_occ (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_en), .rd_req(rd_en),
        .wr_fire(wr_fire), .rd_fire(rd_fire), .full(full), .empty(empty)
    );

    abuf_ptr #(.ADDR_W(ADDR_W), .STEP(WR_B)) u_wr_ptr (
        .clk(clk), .rst_n(rst_n), .adv(wr_fire), .ptr(wr_ptr)
    );

    abuf_ptr #(.ADDR_W(ADDR_W), .STEP(RD_B)) u_rd_ptr (
        .clk(clk), .rst_n(rst_n), .adv(rd_fire), .ptr(rd_ptr)
    );

    abuf_store #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .WR_B(WR_B), .RD_B(RD_B)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_fire(wr_fire), .wr_ptr(wr_ptr), .wr_data(wr_data[WR_B*BYTE_W-1:0]),
        .rd_fire(rd_fire), .rd_ptr(rd_ptr), .rd_data(rd_data)
    );

    // R1: the flags are never both set in the default-sized build.
    assert_flags_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
endmodule

// File: tb/test_asym_byte_buffer.sv
`timescale 1ns/1ps
module test_asym_byte_buffer;
    localparam int WR_W = 32, RD_W = 16, BYTE_W = 8, ADDR_W = 4;
    localparam int WR_B = WR_W / BYTE_W, RD_B = RD_W / BYTE_W, DEPTH = 1 << ADDR_W;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [WR_W-1:0] wr_data = '0;
    logic [RD_W-1:0] rd_data;
    logic full, empty;

    asym_byte_buffer #(.WR_W(WR_W), .RD_W(RD_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) i_asym_byte_buffer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .full(full),
        .rd_en(rd_en), .rd_data(rd_data), .empty(empty)
    );

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [BYTE_W-1:0] model[$];
    logic [RD_W-1:0] exp_rd = '0;

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit m_full();  return model.size() > DEPTH - WR_B; endfunction
    function automatic bit m_empty(); return model.size() < RD_B;         endfunction

    // One clock of stimulus followed by checks against the byte-queue model.
    task automatic cyc(bit w, bit r, logic [WR_W-1:0] d, string req);
        bit wf, rf;
        @(negedge clk);
        wr_en = w; rd_en = r; wr_data = d;
        wf = w && !m_full();
        rf = r && !m_empty();
        #1;
        chk(rd_data == exp_rd, "R7 output holds before edge", rd_data, exp_rd);
        @(posedge clk); #1;
        if (rf) for (int k = 0; k < RD_B; k++) exp_rd[BYTE_W*k +: BYTE_W] = model.pop_front();
        if (wf) for (int k = 0; k < WR_B; k++) model.push_back(d[BYTE_W*k +: BYTE_W]);
        chk(rd_data == exp_rd, req, rd_data, exp_rd);
        chk(full == m_full(), {req, " full flag"}, full, m_full());
        chk(empty == m_empty(), {req, " empty flag"}, empty, m_empty());
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1;
        chk(rd_data == '0, "R1 reset rd_data", rd_data, 0);
        chk(empty == 1'b1, "R1 reset empty", empty, 1);
        chk(full == 1'b0, "R1 reset full", full, 0);
        @(negedge clk); rst_n = 1'b1;

        // R2: lane order.
        cyc(1, 0, 32'h4433_2211, "R2 write lanes");
        cyc(0, 1, '0, "R2 low half");
        chk(rd_data == 16'h2211, "R2 low half value", rd_data, 16'h2211);
        cyc(0, 1, '0, "R2 high half");
        chk(rd_data == 16'h4433, "R2 high half value", rd_data, 16'h4433);

        // R8/R3: fill to full, then one extra write that must be dropped.
        for (int n = 0; n < 4; n++) cyc(1, 0, 32'hA0A0_0000 + n * 32'h0101_0101, "R8 fill");
        chk(full == 1'b1, "R8 full after four writes", full, 1);
        cyc(1, 0, 32'hDEAD_BEEF, "R3 write while full ignored");
        // R4/R8: drain, then extra read that must be dropped.
        for (int n = 0; n < 8; n++) cyc(0, 1, '0, "R3 drain keeps data");
        chk(empty == 1'b1, "R8 empty after eight reads", empty, 1);
        cyc(0, 1, '0, "R4 read while empty ignored");
        cyc(1, 1, 32'h0706_0504, "R4 read with write while empty");

        // R6: simultaneous access returns the older bytes.
        cyc(1, 0, 32'h1B1A_1918, "R6 preload");
        cyc(1, 1, 32'h2B2A_2928, "R6 simultaneous");
        cyc(1, 1, 32'h3B3A_3938, "R6 simultaneous again");

        // R5: many passes round the array in lock step.
        for (int n = 0; n < 12; n++) begin
            cyc(1, 0, $urandom, "R5 wrap write");
            cyc(0, 1, '0, "R5 wrap read");
            cyc(0, 1, '0, "R5 wrap read");
        end

        // Random mix over wrap, limits and simultaneous accesses.
        for (int n = 0; n < 3000; n++) begin
            cyc(($urandom % 3) != 0, ($urandom % 2) != 0, $urandom, "R6 random mix");
        end

        // R1: reset mid-run clears state.
        @(negedge clk); rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        @(posedge clk); #1;
        model.delete(); exp_rd = '0;
        chk(empty == 1'b1 && full == 1'b0 && rd_data == '0, "R1 reset mid-run", {full, empty}, 2'b01);
        @(negedge clk); rst_n = 1'b1;
        cyc(1, 0, 32'h0D0C_0B0A, "R1 restart write");
        cyc(0, 1, '0, "R1 restart read");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule